// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the scan timing for a parallel RGB display panel. A programmable divider derives a pixel clock from the system clock. Samples advance on each falling edge of that pixel clock. Three counters walk the frame: the pixel position within a line, the line within a frame, and the pixel-clock position within the whole frame. Decode logic turns these counts into an active-high horizontal sync, an active-high vertical sync, a data-enable window, and the coordinates of the current active sample.

The active window is not set with porch values. It is placed by a delay measured from the start of the sync period, and its length is set by an active count. This is done separately for the horizontal and vertical axes. The vertical sync width is given in pixel clocks, so it can end partway through a line.

One pixel clock before each active sample, the block raises a request strobe. An upstream pixel FIFO uses this strobe to present the next pixel in time. The block captures the presented pixel at the next sample edge and drives it out. In 24-bit mode the pixel passes through unchanged. In 18-bit mode each colour channel is cut to its upper six bits.

Top module: `lcd_timing_gen`

## Requirements
- R1: `pix_clk` has a period of 2×(`clk_div`+1) system clocks. It stays high for `clk_div`+1 of those clocks.
- R2: Every output except `pix_clk` changes only on the system clock edge where `pix_clk` falls.
- R3: A line lasts `line_len` pixel clocks. `hsync` is high for the first `hs_width` samples of each line, that is, at line positions 0 to `hs_width`-1.
- R4: A frame lasts `frame_len` lines. `vsync` is high for the first `vs_width` pixel clocks of the frame, counted continuously across line boundaries.
- R5: `de` is high when the line position lies in [`h_delay`, `h_delay`+`h_active`) and the line number lies in [`v_delay`, `v_delay`+`v_active`).
- R6: While `de` is high, `pos_x` = line position − `h_delay` and `pos_y` = line number − `v_delay`. Both outputs are 0 while `de` is low.
- R7: `pix_req` is high for the sample just before each active sample in an active line. This means the line position + 1 lies in [`h_delay`, `h_delay`+`h_active`) while the line number is in the vertical window.
- R8: When `mode_rgb666` is 0 and `de` is high, `rgb_out` equals the `pix_in` value captured at that sample edge. `pix_in` is packed as R in bits 23:16, G in 15:8 and B in 7:0. `rgb_out` is 0 whenever `de` is low.
- R9: When `mode_rgb666` is 1 and `de` is high, `rgb_out[17:0]` = {R[7:2], G[7:2], B[7:2]} and `rgb_out[23:18]` = 0.
- R10: While `enable` or `rst` is low-active (that is, `enable` low or `rst` high), all counters are held at zero, `pix_clk` is low, and every output is 0. The first sample after `enable` is set is line 0, position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run control; low holds the block idle |
| clk_div | input | 16 | Pixel clock divider value |
| line_len | input | 16 | Pixel clocks per line |
| frame_len | input | 16 | Lines per frame |
| hs_width | input | 16 | Horizontal sync width in pixel clocks |
| h_delay | input | 16 | Line position of first active sample (at least 1) |
| h_active | input | 16 | Active samples per line |
| vs_width | input | 32 | Vertical sync width in pixel clocks |
| v_delay | input | 16 | First active line |
| v_active | input | 16 | Active lines per frame |
| mode_rgb666 | input | 1 | 1 selects the 18-bit bus, 0 selects the 24-bit bus |
| pix_in | input | 24 | Pixel from the upstream FIFO |
| pix_clk | output | 1 | Divided pixel clock |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| pos_x | output | 16 | Active column |
| pos_y | output | 16 | Active row |
| pix_req | output | 1 | Request for the next pixel |
| rgb_out | output | 24 | Output colour bus |

## Verification
All sampled outputs belong to the system clock edge on which `pix_clk` falls. That is the first edge after `enable` where the divider has run twice through `clk_div`+1 clocks, and every 2×(`clk_div`+1) clocks after that. The bench samples on falling system-clock edges and detects each `pix_clk` fall itself. On each fall it compares all outputs against a position model that it advances by one. Every non-falling sample checks that the outputs held their previous values. The pixel expected on `rgb_out` is the `pix_in` value driven half a clock before that edge. After `enable` is dropped, the idle values are due one system clock later.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;
  localparam int CW = 16;
  localparam int FW = 32;
  localparam int PW = 24;

  typedef struct packed {
    logic [CW-1:0] line_len;
    logic [CW-1:0] frame_len;
    logic [CW-1:0] hs_width;
    logic [CW-1:0] h_delay;
    logic [CW-1:0] h_active;
    logic [FW-1:0] vs_width;
    logic [CW-1:0] v_delay;
    logic [CW-1:0] v_active;
  } scan_cfg_t;
endpackage

// File: rtl/lcdt_clkdiv.sv
module lcdt_clkdiv #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] div,
  output logic          pclk,
  output logic          tick
);
  logic [DW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == div);
  // a sample step happens where pclk goes high -> low
  assign tick = en && wrap && pclk;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      pclk <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      pclk <= ~pclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  p_toggle_at_limit_r1: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (pclk != $past(pclk))) |-> ($past(cnt) == $past(div)));

  p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pclk);
endmodule

// File: rtl/lcdt_scan.sv
module lcdt_scan
  import lcdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  scan_cfg_t     cfg,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output logic [FW-1:0] fcnt
);
  logic line_end, frame_end;

  assign line_end  = (hcnt >= cfg.line_len - 1'b1);
  assign frame_end = (vcnt >= cfg.frame_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hcnt <= '0;
      vcnt <= '0;
      fcnt <= '0;
    end else if (tick) begin
      if (line_end) begin
        hcnt <= '0;
        if (frame_end) begin
          vcnt <= '0;
          fcnt <= '0;
        end else begin
          vcnt <= vcnt + 1'b1;
          fcnt <= fcnt + 1'b1;
        end
      end else begin
        hcnt <= hcnt + 1'b1;
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  p_line_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (en && tick && hcnt == cfg.line_len - 1'b1) |=> (!en || hcnt == '0));

  p_frame_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (en && tick && line_end && vcnt == cfg.frame_len - 1'b1) |=> (!en || (vcnt == '0 && fcnt == '0)));
endmodule

// File: rtl/lcdt_outstage.sv
module lcdt_outstage
  import lcdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  scan_cfg_t     cfg,
  input  logic          mode_rgb666,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] vcnt,
  input  logic [FW-1:0] fcnt,
  input  logic [PW-1:0] pix_in,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] pos_x,
  output logic [CW-1:0] pos_y,
  output logic          pix_req,
  output logic [PW-1:0] rgb_out
);
  logic [CW:0]   h_ext, h_nxt, v_ext, h_lo, h_hi, v_lo, v_hi;
  logic          h_win, h_win_nxt, v_win;
  logic [PW-1:0] pix_fmt;

  always_comb begin
    h_ext     = {1'b0, hcnt};
    h_nxt     = h_ext + 1'b1;
    v_ext     = {1'b0, vcnt};
    h_lo      = {1'b0, cfg.h_delay};
    h_hi      = h_lo + {1'b0, cfg.h_active};
    v_lo      = {1'b0, cfg.v_delay};
    v_hi      = v_lo + {1'b0, cfg.v_active};
    h_win     = (h_ext >= h_lo) && (h_ext < h_hi);
    h_win_nxt = (h_nxt >= h_lo) && (h_nxt < h_hi);
    v_win     = (v_ext >= v_lo) && (v_ext < v_hi);
    if (mode_rgb666)
      pix_fmt = {6'd0, pix_in[23:18], pix_in[15:10], pix_in[7:2]};
    else
      pix_fmt = pix_in;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hsync   <= 1'b0;
      vsync   <= 1'b0;
      de      <= 1'b0;
      pos_x   <= '0;
      pos_y   <= '0;
      pix_req <= 1'b0;
      rgb_out <= '0;
    end else if (tick) begin
      hsync   <= (hcnt < cfg.hs_width);
      vsync   <= (fcnt < cfg.vs_width);
      de      <= h_win && v_win;
      pix_req <= h_win_nxt && v_win;
      pos_x   <= (h_win && v_win) ? hcnt - cfg.h_delay : '0;
      pos_y   <= (h_win && v_win) ? vcnt - cfg.v_delay : '0;
      rgb_out <= (h_win && v_win) ? pix_fmt : '0;
    end
  end

  p_hold_between_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> (!en || ($stable(de) && $stable(hsync) && $stable(vsync) && $stable(rgb_out))));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hsync && !vsync && !de && !pix_req));

  p_blank_rgb_r8: assert property (@(posedge clk) disable iff (rst)
    !de |-> (rgb_out == '0));

  p_blank_coord_r6: assert property (@(posedge clk) disable iff (rst)
    !de |-> (pos_x == '0 && pos_y == '0));

  p_narrow_bus_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && mode_rgb666) |=> (!en || rgb_out[23:18] == 6'd0));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcdt_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic [15:0]   clk_div,
  input  logic [15:0]   line_len,
  input  logic [15:0]   frame_len,
  input  logic [15:0]   hs_width,
  input  logic [15:0]   h_delay,
  input  logic [15:0]   h_active,
  input  logic [31:0]   vs_width,
  input  logic [15:0]   v_delay,
  input  logic [15:0]   v_active,
  input  logic          mode_rgb666,
  input  logic [23:0]   pix_in,
  output logic          pix_clk,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [15:0]   pos_x,
  output logic [15:0]   pos_y,
  output logic          pix_req,
  output logic [23:0]   rgb_out
);
  scan_cfg_t     cfg;
  logic          tick;
  logic [CW-1:0] hcnt, vcnt;
  logic [FW-1:0] fcnt;

  assign cfg = '{line_len: line_len, frame_len: frame_len, hs_width: hs_width,
                 h_delay: h_delay, h_active: h_active, vs_width: vs_width,
                 v_delay: v_delay, v_active: v_active};

  lcdt_clkdiv #(.DW(16)) u_div (
    .clk(clk), .rst(rst), .en(enable), .div(clk_div), .pclk(pix_clk), .tick(tick)
  );

  lcdt_scan u_scan (
    .clk(clk), .rst(rst), .en(enable), .tick(tick), .cfg(cfg),
    .hcnt(hcnt), .vcnt(vcnt), .fcnt(fcnt)
  );

  lcdt_outstage u_out (
    .clk(clk), .rst(rst), .en(enable), .tick(tick), .cfg(cfg),
    .mode_rgb666(mode_rgb666), .hcnt(hcnt), .vcnt(vcnt), .fcnt(fcnt),
    .pix_in(pix_in), .hsync(hsync), .vsync(vsync), .de(de),
    .pos_x(pos_x), .pos_y(pos_y), .pix_req(pix_req), .rgb_out(rgb_out)
  );
endmodule

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;
  localparam int LL = 20, FL = 12, HSW = 3, HD = 5, HA = 8, VSW = 47, VD = 3, VA = 5;

  logic clk = 1'b0;
  logic rst, enable, mode_rgb666, pix_clk, hsync, vsync, de, pix_req;
  logic [15:0] clk_div, pos_x, pos_y;
  logic [23:0] pix_in, rgb_out;

  always #10 clk = ~clk;

  lcd_timing_gen dut_i (
    .clk(clk), .rst(rst), .enable(enable), .clk_div(clk_div),
    .line_len(16'(LL)), .frame_len(16'(FL)), .hs_width(16'(HSW)),
    .h_delay(16'(HD)), .h_active(16'(HA)), .vs_width(32'(VSW)),
    .v_delay(16'(VD)), .v_active(16'(VA)), .mode_rgb666(mode_rgb666),
    .pix_in(pix_in), .pix_clk(pix_clk), .hsync(hsync), .vsync(vsync),
    .de(de), .pos_x(pos_x), .pos_y(pos_y), .pix_req(pix_req), .rgb_out(rgb_out)
  );

  int n_chk = 0, n_bad = 0;
  int mh, mv, mf, cyc, last_fall, hi_cnt;
  bit seen_fall, prev_pclk;
  logic [23:0] cur_pix, prev_rgb;
  logic [5:0]  prev_flags;
  logic [31:0] prev_xy;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [23:0] exp_rgb(input logic [23:0] p, input logic m, input logic d);
    if (!d) return 24'd0;
    if (m) return {6'd0, p[23:18], p[15:10], p[7:2]};
    return p;
  endfunction

  task automatic reset_model();
    mh = 0; mv = 0; mf = 0; seen_fall = 0; hi_cnt = 0;
  endtask

  // one system clock: sample on the falling edge, then drive new inputs
  task automatic step();
    bit e_hw, e_de, e_req;
    @(negedge clk);
    cyc++;
    if (!enable || rst) begin
      chk("R10 idle", {pix_clk, hsync, vsync, de, pix_req}, 0);
      chk("R10 idle bus", {pos_x, pos_y, rgb_out}, 0);
      reset_model();
    end else if (prev_pclk && !pix_clk) begin
      if (seen_fall) begin
        chk("R1 period", cyc - last_fall, 2 * (clk_div + 1));
        chk("R1 high time", hi_cnt, clk_div + 1);
      end
      seen_fall = 1; last_fall = cyc; hi_cnt = 0;
      e_hw  = (mh >= HD) && (mh < HD + HA);
      e_de  = e_hw && (mv >= VD) && (mv < VD + VA);
      e_req = (mh + 1 >= HD) && (mh + 1 < HD + HA) && (mv >= VD) && (mv < VD + VA);
      chk("R3 hsync", hsync, mh < HSW);
      chk("R4 vsync", vsync, mf < VSW);
      chk("R5 de", de, e_de);
      chk("R6 pos_x", pos_x, e_de ? mh - HD : 0);
      chk("R6 pos_y", pos_y, e_de ? mv - VD : 0);
      chk("R7 pix_req", pix_req, e_req);
      chk(mode_rgb666 ? "R9 rgb666" : "R8 rgb888", rgb_out, exp_rgb(cur_pix, mode_rgb666, e_de));
      mh++; mf++;
      if (mh == LL) begin
        mh = 0; mv++;
        if (mv == FL) begin mv = 0; mf = 0; end
      end
    end else begin
      if (pix_clk) hi_cnt++;
      chk("R2 hold flags", {hsync, vsync, de, pix_req}, prev_flags[3:0]);
      chk("R2 hold bus", {pos_x, pos_y, rgb_out}, {prev_xy, prev_rgb});
    end
    prev_pclk = pix_clk;
    prev_flags = {2'b0, hsync, vsync, de, pix_req};
    prev_xy = {pos_x, pos_y};
    prev_rgb = rgb_out;
    cur_pix = $urandom();
    pix_in = cur_pix;
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; enable = 0; mode_rgb666 = 0; clk_div = 16'd1; pix_in = 0; cur_pix = 0;
    cyc = 0; prev_pclk = 0; prev_flags = 0; prev_xy = 0; prev_rgb = 0; last_fall = 0;
    reset_model();
    repeat (3) step();                      // reset state, R10
    rst = 0;
    repeat (3) step();
    enable = 1;                             // R8 path, divider 1
    repeat (2 * FL * LL * 4 + 10) step();
    enable = 0;                             // disable mid-frame, R10
    repeat (5) step();
    mode_rgb666 = 1; clk_div = 16'd0;       // R9 path, fastest divider
    enable = 1;
    repeat (2 * FL * LL * 2 + 6) step();
    enable = 0;
    repeat (4) step();
    mode_rgb666 = 0; clk_div = 16'(2 + $urandom_range(0, 2)); // random slower divider
    enable = 1;
    repeat (FL * LL * 2 * (clk_div + 1) + 30) step();
    rst = 1;                                // synchronous reset while running, R10
    repeat (3) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule